// File: doc/BRIEF.md
# Segment Limit Check and Linear Address Generator

This block sits in the memory-access path of a segmented addressing unit. For each access it takes the descriptor already cached for the segment and a request. The descriptor gives a base, a 20-bit limit, a granularity flag, a default-size/bound flag, an expand-down flag and a present flag. The request gives an offset, a size code and a strobe. One cycle later the block returns either the linear address, or a single fault flag that blocks the access.

The limit can count bytes or 4 KB units. The offset and the last byte touched are checked against the window that the segment allows. For expand-up segments that window is zero through the limit. For expand-down segments it is everything above the limit, up to a ceiling of 64 KB−1 or 4 GB−1. Any access through a descriptor marked not present faults. Adding the base to the offset simply wraps at 2^32 and never faults by itself.

Top module: `seg_addr_gen`

## Requirements
- R1: One cycle after an accepted request, out_valid is 1 and out_addr equals (desc_base + req_offset) modulo 2^32; a wrap past 2^32 raises no fault.
- R2: With desc_gran=0 the effective limit is desc_limit zero-extended to 32 bits, and the granularity flag never alters the base used for out_addr.
- R3: With desc_gran=1 the effective limit is desc_limit followed by twelve 1 bits (desc_limit*4096 + 4095).
- R4: req_size encodes the byte count as 0→1, 1→2, 2→4, 3→8; the last byte offset req_offset + bytes − 1 is formed in 33 bits, so a carry past 2^32 counts as out of range.
- R5: For desc_expdown=0 an access is legal only if the last byte offset is at most the effective limit.
- R6: For desc_expdown=1 an access is legal only if req_offset is greater than the effective limit and the last byte offset is at most the upper bound.
- R7: The expand-down upper bound is 0xFFFFFFFF when desc_big=1 and 0x0000FFFF when desc_big=0.
- R8: A request with desc_present=0 faults whatever its offset, size and limit.
- R9: out_valid and out_fault are never both 1; out_addr reads 0 whenever out_valid is 0.
- R10: A cycle with req_valid=0 gives out_valid=0 and out_fault=0 on the next cycle.
- R11: While rst is high and on the cycle after it, out_valid, out_fault and out_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_offset | input | 32 | Offset within the segment |
| req_size | input | 2 | Size code (0:1, 1:2, 2:4, 3:8 bytes) |
| desc_base | input | 32 | Segment base |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | 1 = limit counts 4 KB units |
| desc_big | input | 1 | Expand-down ceiling select (1 = 4 GB−1) |
| desc_expdown | input | 1 | 1 = expand-down data segment |
| desc_present | input | 1 | Segment present |
| out_valid | output | 1 | Registered: access legal, address valid |
| out_addr | output | 32 | Registered linear address |
| out_fault | output | 1 | Registered: limit or not-present exception |

## Verification
The assertions assume that the descriptor and request inputs are stable across the sampling edge and free of X, and that req_valid is held low throughout reset. The bench drives every input on the falling edge and samples on the clock edge after the one that registers the result. It keeps req_valid low during reset. Random offsets are drawn near the effective limit, the 64 KB and 4 GB ceilings and the 2^32 wrap, so that both sides of each bound are exercised and not only legal accesses.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W  = 32;
  localparam int LIM_W   = 20;
  localparam int GRAN_SH = 12;
  localparam int SMALL_W = 16;

  typedef enum logic [1:0] {
    SZ_B1 = 2'd0,
    SZ_B2 = 2'd1,
    SZ_B4 = 2'd2,
    SZ_B8 = 2'd3
  } size_code_t;

  function automatic logic [3:0] size_minus_one(input logic [1:0] code);
    case (size_code_t'(code))
      SZ_B1:   return 4'd0;
      SZ_B2:   return 4'd1;
      SZ_B4:   return 4'd3;
      default: return 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/seg_lim_unit.sv
module seg_lim_unit
  import seg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LIM_W,
  parameter int GS = GRAN_SH,
  parameter int SW = SMALL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] limit,
  input  logic          gran,
  input  logic          big,
  output logic [AW-1:0] eff_lim,
  output logic [AW-1:0] upper
);
  localparam int SCALED_W = LW + GS;

  logic [AW-1:0] lim_bytes;
  logic [AW-1:0] lim_pages;

  assign lim_bytes = {{(AW-LW){1'b0}}, limit};

  generate
    if (SCALED_W >= AW) begin : g_full
      logic [SCALED_W-1:0] scaled;
      assign scaled    = {limit, {GS{1'b1}}};
      assign lim_pages = scaled[AW-1:0];
    end else begin : g_pad
      assign lim_pages = {{(AW-SCALED_W){1'b0}}, limit, {GS{1'b1}}};
    end
  endgenerate

  assign eff_lim = gran ? lim_pages : lim_bytes;
  assign upper   = big ? {AW{1'b1}} : {{(AW-SW){1'b0}}, {SW{1'b1}}};

  // R2: byte granularity never reaches above the raw limit width
  p_byte_gran_r2: assert property (@(posedge clk) disable iff (rst)
    !gran |-> (eff_lim >> LW) == '0);
  // R3: page granularity always ends on a 4 KB boundary minus one
  p_page_gran_r3: assert property (@(posedge clk) disable iff (rst)
    gran |-> &eff_lim[GS-1:0]);
endmodule

// File: rtl/seg_range_chk.sv
module seg_range_chk
  import seg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] offset,
  input  logic [1:0]    size,
  input  logic [AW-1:0] eff_lim,
  input  logic [AW-1:0] upper,
  input  logic          expdown,
  input  logic          present,
  output logic          legal
);
  logic [AW:0] last_byte;
  logic        up_ok;
  logic        dn_ok;

  assign last_byte = {1'b0, offset} + {{(AW-3){1'b0}}, size_minus_one(size)};
  assign up_ok     = last_byte <= {1'b0, eff_lim};
  assign dn_ok     = (offset > eff_lim) && (last_byte <= {1'b0, upper});
  assign legal     = present && (expdown ? dn_ok : up_ok);

  // R4: an access whose last byte carries past the address space is never legal
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    last_byte[AW] |-> !legal);
  // R6: an expand-down access at or below the limit is never legal
  p_dn_floor_r6: assert property (@(posedge clk) disable iff (rst)
    (expdown && offset <= eff_lim) |-> !legal);
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          legal,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic          ok_q,
  output logic          fault_q,
  output logic [AW-1:0] addr_q
);
  logic [AW-1:0] lin;
  assign lin = base + offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q    <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      ok_q    <= req && legal;
      fault_q <= req && !legal;
      addr_q  <= (req && legal) ? lin : '0;
    end
  end

  // R9: result and exception are exclusive
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(ok_q && fault_q));
  // R9: address is zero whenever no valid result is presented
  p_addr_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !ok_q |-> addr_q == '0);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int LW = LIM_W,
  parameter int GS = GRAN_SH,
  parameter int SW = SMALL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_offset,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] desc_base,
  input  logic [LW-1:0] desc_limit,
  input  logic          desc_gran,
  input  logic          desc_big,
  input  logic          desc_expdown,
  input  logic          desc_present,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_fault
);
  logic [AW-1:0] eff_lim;
  logic [AW-1:0] upper;
  logic          legal;

  seg_lim_unit #(.AW(AW), .LW(LW), .GS(GS), .SW(SW)) u_lim (
    .clk(clk), .rst(rst), .limit(desc_limit), .gran(desc_gran),
    .big(desc_big), .eff_lim(eff_lim), .upper(upper)
  );

  seg_range_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .offset(req_offset), .size(req_size),
    .eff_lim(eff_lim), .upper(upper), .expdown(desc_expdown),
    .present(desc_present), .legal(legal)
  );

  seg_out_stage #(.AW(AW)) u_out (
    .clk(clk), .rst(rst), .req(req_valid), .legal(legal),
    .base(desc_base), .offset(req_offset),
    .ok_q(out_valid), .fault_q(out_fault), .addr_q(out_addr)
  );

  // R1: a valid result carries base plus offset of the previous cycle
  p_lin_sum_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_addr == $past(desc_base + req_offset));
  // R8: an absent segment always faults
  p_absent_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !desc_present) |=> (out_fault && !out_valid));
  // R10: no request gives no result
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && !out_fault));
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] desc_base = '0;
  logic [19:0] desc_limit = '0;
  logic        desc_gran = 1'b0, desc_big = 1'b0, desc_expdown = 1'b0, desc_present = 1'b1;
  logic        out_valid, out_fault;
  logic [31:0] out_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_addr_gen u0 (.*);

  function automatic logic [31:0] m_lim(input logic [19:0] l, input logic g);
    return g ? {l, 12'hFFF} : {12'h0, l};
  endfunction

  function automatic bit m_legal(input logic [31:0] off, input logic [1:0] sz,
                                 input logic [19:0] l, input logic g, input logic b,
                                 input logic e, input logic p);
    logic [32:0] last;
    logic [31:0] lim, up;
    lim  = m_lim(l, g);
    up   = b ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    last = {1'b0, off} + 33'((1 << sz) - 1);
    if (!p) return 0;
    if (e) return (off > lim) && (last <= {1'b0, up});
    return last <= {1'b0, lim};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] off, input logic [1:0] sz,
                     input logic [31:0] b, input logic [19:0] l, input logic g,
                     input logic bg, input logic e, input logic p);
    bit ok;
    @(negedge clk);
    req_valid = 1; req_offset = off; req_size = sz; desc_base = b; desc_limit = l;
    desc_gran = g; desc_big = bg; desc_expdown = e; desc_present = p;
    ok = m_legal(off, sz, l, g, bg, e, p);
    @(negedge clk);
    req_valid = 0;
    chk(tag, "valid", {31'b0, out_valid}, {31'b0, ok});
    chk(tag, "fault", {31'b0, out_fault}, {31'b0, !ok});
    chk(ok ? "R1" : "R9", "addr", out_addr, ok ? b + off : 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: got timeout exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EA5_0001));
    repeat (3) @(negedge clk);
    chk("R11", "valid in reset", {31'b0, out_valid}, 32'h0);
    chk("R11", "fault in reset", {31'b0, out_fault}, 32'h0);
    chk("R11", "addr in reset", out_addr, 32'h0);
    rst = 0;
    @(negedge clk);
    chk("R11", "valid after reset", {31'b0, out_valid}, 32'h0);
    chk("R10", "idle fault", {31'b0, out_fault}, 32'h0);

    // directed corners
    run("R1",  32'h0000_0010, 2'd2, 32'hFFFF_FFF8, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    run("R2",  32'h0000_1000, 2'd0, 32'h0001_0000, 20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R2",  32'h0000_0FFF, 2'd0, 32'h0001_0000, 20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R3",  32'h0000_1FFF, 2'd0, 32'h0000_0000, 20'h00001, 1'b1, 1'b0, 1'b0, 1'b1);
    run("R3",  32'h0000_2000, 2'd0, 32'h0000_0000, 20'h00001, 1'b1, 1'b0, 1'b0, 1'b1);
    run("R4",  32'h0000_0FFC, 2'd2, 32'h0000_0100, 20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R4",  32'h0000_0FFD, 2'd2, 32'h0000_0100, 20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R4",  32'h0000_0FF8, 2'd3, 32'h0000_0100, 20'h00FFF, 1'b0, 1'b0, 1'b0, 1'b1);
    run("R4",  32'hFFFF_FFFE, 2'd1, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    run("R4",  32'hFFFF_FFFF, 2'd1, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b1);
    run("R6",  32'h0000_0100, 2'd0, 32'h0000_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 1'b1);
    run("R6",  32'h0000_0101, 2'd0, 32'h0000_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 1'b1);
    run("R7",  32'h0000_FFFE, 2'd1, 32'h0000_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 1'b1);
    run("R7",  32'h0000_FFFF, 2'd1, 32'h0000_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 1'b1);
    run("R7",  32'h0001_0000, 2'd0, 32'h0000_0000, 20'h00100, 1'b0, 1'b1, 1'b1, 1'b1);
    run("R7",  32'h0001_0000, 2'd0, 32'h0000_0000, 20'h00100, 1'b0, 1'b0, 1'b1, 1'b1);
    run("R8",  32'h0000_0000, 2'd0, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    run("R5",  32'h0000_0000, 2'd0, 32'h0000_0000, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b1);

    @(negedge clk);
    chk("R10", "idle valid", {31'b0, out_valid}, 32'h0);
    chk("R10", "idle fault", {31'b0, out_fault}, 32'h0);

    // constrained random around the bounds
    for (int i = 0; i < 400; i++) begin
      logic [19:0] l;
      logic [31:0] off, lim;
      logic g, bg, e, p;
      logic [1:0] sz;
      string tg;
      l   = 20'($urandom);
      g   = 1'($urandom);
      bg  = 1'($urandom);
      e   = 1'($urandom);
      p   = ($urandom % 8) != 0;
      sz  = 2'($urandom);
      lim = m_lim(l, g);
      case ($urandom % 5)
        0: off = lim - 32'($urandom % 8);
        1: off = lim + 32'($urandom % 8);
        2: off = 32'h0000_FFF8 + 32'($urandom % 16);
        3: off = 32'hFFFF_FFF8 + 32'($urandom % 8);
        default: off = $urandom;
      endcase
      tg = !p ? "R8" : (e ? "R6" : "R5");
      run(tg, off, sz, $urandom, l, g, bg, e, p);
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule